// File: doc/BRIEF.md
# Colour Wheel and Column Sweep Sequencer

This block produces a slowly rotating hue for a bank of LED drivers. Three 8-bit colour components move around a fixed six-phase wheel: in every phase exactly one component ramps, up or down, by one count per tick. The other two components stay at their limits. Each component value is copied to every channel lane, so all channels show the same colour.

Alongside the colour, a column index moves back and forth across the channel range. It moves once every sixteen ticks. On the way up it jumps over columns 5 to 7, and on the way down it jumps from 8 straight to 4. It reverses direction at column 12 and at column 0. A downstream table writer uses this index as the highlighted column.

The tick input is a single-cycle enable. While it is low, nothing in the block changes.

Top module: `cw_wheel`

## Requirements
- R1: After reset the outputs are red=0xFF, green=0x00 and blue=0x00, the column index is 0 and the sweep direction is upward. The wheel starts in the phase where green rises.
- R2: In a cycle where tick_i is low, the colour lanes and the column index keep their values.
- R3: In the first phase, green rises by 1 per tick. The tick that brings green to 0xFF also moves the wheel to the second phase, where red falls.
- R4: Red falls by 1 per tick to 0x00, which starts the third phase. In the third phase blue rises by 1 per tick to 0xFF, which starts the fourth phase.
- R5: In the fourth phase green falls to 0x00. In the fifth phase red rises to 0xFF. In the sixth phase blue falls to 0x00 and the wheel returns to the first phase, so the full wheel lasts 1530 ticks.
- R6: Every tick changes exactly one component, by exactly 1.
- R7: The column index changes only on every 16th tick since reset, that is ticks 16, 32, 48 and so on.
- R8: Moving up, the index steps by +1 but never takes the values 5, 6 or 7. A step that would reach 5 lands on 8 instead. Reaching 12 turns the direction downward.
- R9: Moving down, the index steps by -1, and a step that would reach 7 lands on 4 instead. Reaching 0 turns the direction upward. The visit order therefore repeats with period 18 moves: 0,1,2,3,4,8,9,10,11,12,11,10,9,8,4,3,2,1.
- R10: Each of the 16 lanes of a colour output equals that colour's component. Lane i occupies bits [8i+7:8i].
- R11: When a phase change and a column move fall on the same tick, both take effect in that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | advance enable, one step per high cycle |
| red_ch_o | output | 128 | red component broadcast to 16 lanes of 8 bits |
| grn_ch_o | output | 128 | green component broadcast to 16 lanes of 8 bits |
| blu_ch_o | output | 128 | blue component broadcast to 16 lanes of 8 bits |
| pos_o | output | 4 | highlighted column index |

## Verification
The wheel's phase change and the column move can fall on the same tick. Phase changes happen every 255 ticks and moves every 16 ticks, so the first tick that carries both is tick 4080. At that tick green reaches 0 and the column moves from 2 to 3. The bench drives ticks without a break past that point. It compares every lane and the column index with closed-form values computed from the tick count, and it checks that both changes appear in the same sampled cycle. Idle cycles between ticks early in the run exercise the hold behaviour.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [2:0] {
    PH_G_UP, PH_R_DN, PH_B_UP, PH_G_DN, PH_R_UP, PH_B_DN
  } phase_e;

  function automatic logic [1:0] ph_comp(phase_e p);
    case (p)
      PH_R_DN, PH_R_UP: return 2'd0;
      PH_G_UP, PH_G_DN: return 2'd1;
      default:          return 2'd2;
    endcase
  endfunction

  function automatic logic ph_up(phase_e p);
    return (p == PH_G_UP) || (p == PH_B_UP) || (p == PH_R_UP);
  endfunction

  function automatic phase_e ph_next(phase_e p);
    case (p)
      PH_G_UP: return PH_R_DN;
      PH_R_DN: return PH_B_UP;
      PH_B_UP: return PH_G_DN;
      PH_G_DN: return PH_R_UP;
      PH_R_UP: return PH_B_DN;
      default: return PH_G_UP;
    endcase
  endfunction
endpackage

// File: rtl/cw_ramp.sv
module cw_ramp
  import cw_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [CW-1:0] red_o,
  output logic [CW-1:0] grn_o,
  output logic [CW-1:0] blu_o
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  phase_e        ph_q;
  logic [CW-1:0] comp_q [3];
  logic [1:0]    idx;
  logic [CW-1:0] cur, nxt;
  logic          done;

  always_comb begin
    idx  = ph_comp(ph_q);
    cur  = comp_q[idx];
    nxt  = ph_up(ph_q) ? cur + 1'b1 : cur - 1'b1;
    done = ph_up(ph_q) ? (nxt == MAX) : (nxt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_G_UP;
      comp_q[0] <= MAX;
      comp_q[1] <= '0;
      comp_q[2] <= '0;
    end else if (tick_i) begin
      comp_q[idx] <= nxt;
      if (done) ph_q <= ph_next(ph_q);
    end
  end

  assign red_o = comp_q[0];
  assign grn_o = comp_q[1];
  assign blu_o = comp_q[2];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(red_o) && $stable(grn_o) && $stable(blu_o));
  p_g_up_ctx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_G_UP |-> red_o == MAX && blu_o == '0);
  p_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_G_UP && tick_i && grn_o == MAX - 1'b1 |=> ph_q == PH_R_DN);
  p_b_up_ctx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_B_UP |-> grn_o == MAX && red_o == '0);
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_B_DN && tick_i && blu_o == CW'(1) |=> ph_q == PH_G_UP && blu_o == '0);
endmodule

// File: rtl/cw_sweep.sv
module cw_sweep #(
  parameter int STEP_DIV = 16,
  parameter int POS_TOP  = 12,
  parameter int SKIP_LO  = 5,
  parameter int SKIP_HI  = 8,
  localparam int PW = $clog2(POS_TOP + 1),
  localparam int SW = $clog2(STEP_DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [PW-1:0] pos_o
);
  logic [SW-1:0] step_q;
  logic          wrap;
  logic          up_q;
  logic [PW-1:0] nx;

  assign wrap = tick_i && (step_q == SW'(STEP_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (wrap)   step_q <= '0;
    else if (tick_i) step_q <= step_q + 1'b1;
  end

  assign nx = up_q ? pos_o + 1'b1 : pos_o - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      up_q  <= 1'b1;
    end else if (wrap) begin
      if (up_q) begin
        pos_o <= (nx == PW'(SKIP_LO)) ? PW'(SKIP_HI) : nx;
        if (nx == PW'(POS_TOP)) up_q <= 1'b0;
      end else begin
        pos_o <= (nx == PW'(SKIP_HI - 1)) ? PW'(SKIP_LO - 1) : nx;
        if (nx == '0) up_q <= 1'b1;
      end
    end
  end

  p_still_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(pos_o));
  p_no_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o < PW'(SKIP_LO) || (pos_o >= PW'(SKIP_HI) && pos_o <= PW'(POS_TOP)));
  p_skip_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && up_q && pos_o == PW'(SKIP_LO - 1) |=> pos_o == PW'(SKIP_HI));
  p_turn_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && pos_o == PW'(POS_TOP) |=> pos_o == PW'(POS_TOP - 1));
endmodule

// File: rtl/cw_fanout.sv
module cw_fanout #(
  parameter int CW  = 8,
  parameter int NCH = 16
) (
  input  logic [CW-1:0]     val_i,
  output logic [NCH*CW-1:0] lanes_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_lane
    assign lanes_o[i*CW +: CW] = val_i;
  end
endmodule

// File: rtl/cw_wheel.sv
module cw_wheel #(
  parameter int CW       = 8,
  parameter int NCH      = 16,
  parameter int STEP_DIV = 16,
  parameter int POS_TOP  = 12,
  parameter int SKIP_LO  = 5,
  parameter int SKIP_HI  = 8,
  localparam int PW = $clog2(POS_TOP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [NCH*CW-1:0] red_ch_o,
  output logic [NCH*CW-1:0] grn_ch_o,
  output logic [NCH*CW-1:0] blu_ch_o,
  output logic [PW-1:0]     pos_o
);
  logic [CW-1:0] red, grn, blu;

  cw_ramp #(.CW(CW)) u_ramp (
    .clk_i, .rst_ni, .tick_i,
    .red_o(red), .grn_o(grn), .blu_o(blu)
  );

  cw_sweep #(
    .STEP_DIV(STEP_DIV), .POS_TOP(POS_TOP), .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)
  ) u_sweep (
    .clk_i, .rst_ni, .tick_i, .pos_o
  );

  cw_fanout #(.CW(CW), .NCH(NCH)) u_fan_r (.val_i(red), .lanes_o(red_ch_o));
  cw_fanout #(.CW(CW), .NCH(NCH)) u_fan_g (.val_i(grn), .lanes_o(grn_ch_o));
  cw_fanout #(.CW(CW), .NCH(NCH)) u_fan_b (.val_i(blu), .lanes_o(blu_ch_o));
endmodule

// File: tb/cw_wheel_test.sv
module cw_wheel_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic [127:0] red_ch, grn_ch, blu_ch;
  logic [3:0]   pos;

  int n_run = 0, n_fail = 0;
  int n = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_wheel uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .red_ch_o(red_ch), .grn_ch_o(grn_ch), .blu_ch_o(blu_ch), .pos_o(pos)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, n);
    end
  endtask

  function automatic void exp_col(int t, output int r, output int g, output int b);
    int m = t % 1530;
    int p = m / 255;
    int k = m % 255;
    case (p)
      0: begin r = 255;     g = k;       b = 0;       end
      1: begin r = 255 - k; g = 255;     b = 0;       end
      2: begin r = 0;       g = 255;     b = k;       end
      3: begin r = 0;       g = 255 - k; b = 255;     end
      4: begin r = k;       g = 0;       b = 255;     end
      default: begin r = 255; g = 0;     b = 255 - k; end
    endcase
  endfunction

  function automatic int up_pos(int k);
    return (k < 5) ? k : k + 3;
  endfunction

  function automatic int exp_pos(int t);
    int j = (t / 16) % 18;
    return (j <= 9) ? up_pos(j) : up_pos(18 - j);
  endfunction

  function automatic string col_req(int t);
    int p = (t % 1530) / 255;
    return (p == 0) ? "R3" : (p <= 2) ? "R4" : "R5";
  endfunction

  // R10: every lane must carry the value; returns first mismatching lane value
  function automatic int lane_val(logic [127:0] v, int e);
    for (int i = 0; i < 16; i++)
      if (int'(v[i*8 +: 8]) != e) return int'(v[i*8 +: 8]);
    return e;
  endfunction

  int pr, pg, pb, ppos;

  task automatic check_all();
    int r, g, b, d;
    string pq;
    exp_col(n, r, g, b);
    chk(col_req(n), int'(red_ch[7:0]), r);
    chk(col_req(n), int'(grn_ch[7:0]), g);
    chk(col_req(n), int'(blu_ch[7:0]), b);
    chk("R10", lane_val(red_ch, r), r);
    chk("R10", lane_val(grn_ch, g), g);
    chk("R10", lane_val(blu_ch, b), b);
    if (n % 16 != 0 || n == 0) pq = "R7";
    else if ((n / 16) % 18 >= 1 && (n / 16) % 18 <= 9) pq = "R8";
    else pq = "R9";
    chk(pq, int'(pos), exp_pos(n));
  endtask

  task automatic snap();
    pr = int'(red_ch[7:0]); pg = int'(grn_ch[7:0]); pb = int'(blu_ch[7:0]); ppos = int'(pos);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(red_ch[7:0]), 255);
    chk("R1", int'(grn_ch[7:0]), 0);
    chk("R1", int'(blu_ch[7:0]), 0);
    chk("R1", int'(pos), 0);
    rst_ni = 1'b1;
    snap();
    // idle cycles interleaved with ticks: R2
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (tick_i) n++;
      if (!tick_i && c > 0) begin
        chk("R2", int'(red_ch[7:0]), pr);
        chk("R2", int'(grn_ch[7:0]), pg);
        chk("R2", int'(blu_ch[7:0]), pb);
        chk("R2", int'(pos), ppos);
      end
      check_all();
      snap();
      tick_i = (c % 3 == 0);
    end
    // continuous ticks through the first coincidence at 4080
    while (n < 4300) begin
      @(negedge clk);
      if (tick_i) begin
        n++;
        d = (int'(red_ch[7:0]) - pr) * (int'(red_ch[7:0]) - pr)
          + (int'(grn_ch[7:0]) - pg) * (int'(grn_ch[7:0]) - pg)
          + (int'(blu_ch[7:0]) - pb) * (int'(blu_ch[7:0]) - pb);
        chk("R6", d, 1);
      end
      check_all();
      if (n == 4080) begin
        // R11: phase 3 -> 4 edge and column move 2 -> 3 in one tick
        chk("R11", pg, 1);
        chk("R11", int'(grn_ch[7:0]), 0);
        chk("R11", ppos, 2);
        chk("R11", int'(pos), 3);
      end
      snap();
      tick_i = 1'b1;
    end
    // mid-run reset returns to R1 state
    tick_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", int'(red_ch[7:0]), 255);
    chk("R1", int'(grn_ch[7:0]), 0);
    chk("R1", int'(blu_ch[7:0]), 0);
    chk("R1", int'(pos), 0);
    rst_ni = 1'b1;
    n = 0;
    tick_i = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      n++;
      check_all();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule